// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration bytes and presents them as one parallel output vector. It answers two fixed address bytes: one that opens a write and one that opens a read. A write is a simplified block transfer. The slave acknowledges and drops the two header bytes that follow the address, a command code and a byte count. Every later byte fills the next configuration byte, starting at byte 0. A read returns the number of configuration bytes first and then the bytes themselves, lowest first.

The bus lines are sampled by the system clock through synchronisers. START and STOP are recognised as SDA edges while SCL is high. The slave drives SDA only through an open-drain enable (`sda_oe`, 1 pulls the line low). It does not handle arbitration and never stretches the clock. The bus must run slowly enough that each SCL phase lasts several system clocks.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, configuration byte 0 reads 0x00 and bytes 1 to 5 read 0xFF, and `sda_oe` is 0. Byte k sits at `cfg_out[8k+7:8k]`.
- R2: The address bytes 0xD2 (write) and 0xD3 (read), sent MSB first, are acknowledged: SDA is held low during the ninth clock.
- R3: Any other address byte gets no acknowledge. Further bytes up to the next START are also not acknowledged and do not change the configuration.
- R4: In a write, the first two bytes after the address are acknowledged and change no configuration byte.
- R5: Write data bytes load configuration bytes 0, 1, 2 and so on in ascending order, taking the first data byte into byte 0.
- R6: A STOP after any complete byte ends the write. Bytes already received keep their new values, and the others keep their previous values.
- R7: Every byte of a write to 0xD2 is acknowledged, including data bytes past the sixth. Those extra bytes are discarded.
- R8: In a read, the slave sends the value 6 first and then bytes 0 to 5, MSB first. It moves to the next byte only after the host acknowledges. Bytes requested after byte 5 read 0xFF.
- R9: A host not-acknowledge ends the read. SDA is released and stays released, and a following transfer is served normally.
- R10: A repeated START restarts the address phase without a STOP, so a write can be followed directly by a read.
- R11: The slave changes its SDA drive only while SCL is low, so SDA stays constant while SCL is high during data and acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_out | output | 48 | Configuration bytes, byte k at bits 8k+7..8k |

## Verification
A wrong byte index or a missed header count shows up on `cfg_out` as soon as the STOP that closes the write. The same fault appears earlier on a read, in the first data byte after the count. A wrong protocol state shows up within one bit time as a missing or extra low level on SDA in an acknowledge slot. A drive change while SCL is high would show as a false START or STOP seen by the host. An index that fails to saturate shows up on a read beyond the last byte, where 0xFF is expected, or in configuration bytes changed by overflow writes.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_ACK   = 3'd2,
    ST_RX    = 3'd3,
    ST_TX    = 3'd4,
    ST_TXACK = 3'd5
  } link_st_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned HDR_BYTES = 2;

endpackage

// File: rtl/cfg_i2c_rst_sync.sv
module cfg_i2c_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n = rst_q[1];

endmodule

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic            scl_prev;
  logic            sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[STAGES-1];
  assign sda_lvl  = sda_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_prev = sda_p[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs #(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned IDX_W     = 4,
  parameter logic [7:0]  BYTE0_RST = 8'h00,
  parameter logic [7:0]  REST_RST  = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_sel,
  input  logic [7:0]             wr_data,
  input  logic [IDX_W-1:0]       rd_sel,
  output logic [7:0]             rd_data,
  output logic [8*NUM_BYTES-1:0] cfg_q
);

  logic [7:0] mem [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [7:0] RST_VAL = (g == 0) ? BYTE0_RST : REST_RST;
    logic hit;
    assign hit = wr_en && (wr_sel == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= RST_VAL;
      else if (hit) mem[g] <= wr_data;
    end

    assign cfg_q[8*g +: 8] = mem[g];
  end

  // read select 0 is the byte count, 1..NUM_BYTES the bytes, beyond is 0xFF
  always_comb begin
    rd_data = 8'hFF;
    if (rd_sel == '0) rd_data = 8'(NUM_BYTES);
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (rd_sel == IDX_W'(k + 1)) rd_data = mem[k];
    end
  end

  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned IDX_W     = 4,
  parameter logic [6:0]  DEV_ADDR  = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_sel,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_sel,
  output logic             sda_oe
);

  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES + HDR_BYTES);
  localparam logic [3:0]       BIT_END  = 4'(BYTE_BITS);

  link_st_e         st_q, st_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             rd_q, rd_n;
  logic             mack_q, mack_n;
  logic             oe_q, oe_n;
  logic             idx_step;
  logic             bus_evt;

  assign bus_evt = start_det | stop_det;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    idx_n    = idx_q;
    rd_n     = rd_q;
    mack_n   = mack_q;
    wr_en    = 1'b0;
    idx_step = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      idx_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR, ST_RX: begin
          if (scl_rise && (cnt_q < BIT_END)) begin
            sh_n  = {sh_q[6:0], sda_lvl};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && (cnt_q == BIT_END)) begin
            cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q == {DEV_ADDR, 1'b0}) begin
                st_n = ST_ACK;
                rd_n = 1'b0;
              end else if (sh_q == {DEV_ADDR, 1'b1}) begin
                st_n = ST_ACK;
                rd_n = 1'b1;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              st_n     = ST_ACK;
              wr_en    = (idx_q >= IDX_HDR) && (idx_q < IDX_LAST);
              idx_step = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rd_q) begin
              st_n     = ST_TX;
              sh_n     = rd_data;
              idx_step = 1'b1;
            end else begin
              st_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == BIT_END - 4'd1) begin
              st_n   = ST_TXACK;
              cnt_n  = '0;
              mack_n = 1'b0;
            end else begin
              cnt_n = cnt_q + 4'd1;
              sh_n  = {sh_q[6:0], 1'b1};
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n     = ST_TX;
              sh_n     = rd_data;
              cnt_n    = '0;
              idx_step = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
    if (idx_step && (idx_q != IDX_LAST)) idx_n = idx_q + IDX_W'(1);
    oe_n = (st_n == ST_ACK) || ((st_n == ST_TX) && !sh_n[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      rd_q   <= rd_n;
      mack_q <= mack_n;
      oe_q   <= oe_n;
    end
  end

  assign wr_sel  = idx_q - IDX_HDR;
  assign wr_data = sh_q;
  assign rd_sel  = idx_q;
  assign sda_oe  = oe_q;

  a_r11_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  a_r3_foreign_addr_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && scl_fall && cnt_q == BIT_END && !bus_evt && sh_q[7:1] != DEV_ADDR)
    |=> (!sda_oe && st_q == ST_IDLE));

  a_r7_write_byte_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX && scl_fall && cnt_q == BIT_END && !bus_evt) |=> sda_oe);

  a_r9_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TXACK && scl_fall && !mack_q && !bus_evt) |=> (st_q == ST_IDLE && !sda_oe));

  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sel < IDX_W'(NUM_BYTES)));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int unsigned NUM_BYTES   = 6,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter logic [7:0]  BYTE0_RST   = 8'h00,
  parameter logic [7:0]  REST_RST    = 8'hFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [8*NUM_BYTES-1:0] cfg_out
);

  localparam int unsigned IDX_W = $clog2(NUM_BYTES + 3);

  logic             rst_sn;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_sel, rd_sel;
  logic [7:0]       wr_data, rd_data;

  cfg_i2c_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sn)
  );

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_i2c_ctrl #(
    .NUM_BYTES (NUM_BYTES),
    .IDX_W     (IDX_W),
    .DEV_ADDR  (DEV_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .sda_oe    (sda_oe)
  );

  cfg_i2c_regs #(
    .NUM_BYTES (NUM_BYTES),
    .IDX_W     (IDX_W),
    .BYTE0_RST (BYTE0_RST),
    .REST_RST  (REST_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .cfg_q   (cfg_out)
  );

endmodule

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg;
  logic        sda_bus;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_slave uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .cfg_out (cfg)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] mdl [6];

  // {data byte count, byte for cfg 0, 1, 2, 3, 4, 5}
  localparam logic [55:0] VEC [4] = '{
    {8'd6, 48'h11_22_33_44_55_66},
    {8'd3, 48'hA5_5A_C3_00_00_00},
    {8'd1, 48'h7E_00_00_00_00_00},
    {8'd0, 48'hDE_AD_BE_EF_00_00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model_vec();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = mdl[k];
    return v;
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF / 2);
    ack_n = sda_bus;
    tick(HALF / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic a, b;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(2);
      a = sda_bus;
      tick(HALF - 4);
      b = sda_bus;
      tick(2);
      scl_m = 1'b0; tick(2);
      check("R11 data held while SCL high", 48'(b), 48'(a));
      d = {d[6:0], a};
    end
    send_bit(nack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    int         n;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state
    mdl[0] = 8'h00;
    for (int k = 1; k < 6; k++) mdl[k] = 8'hFF;
    check("R1 reset configuration", cfg, 48'hFFFF_FFFF_FF00);
    check("R1 reset sda released", 48'(sda_oe), 48'd0);

    // table of block writes
    for (int v = 0; v < 4; v++) begin
      n = int'(VEC[v][55:48]);
      bus_start;
      wr_byte(8'hD2, a); check("R2 write address ack", 48'(a), 48'd0);
      wr_byte(8'h9C, a); check("R4 command byte ack", 48'(a), 48'd0);
      wr_byte(8'h37, a); check("R4 count byte ack", 48'(a), 48'd0);
      for (int k = 0; k < n; k++) begin
        wr_byte(VEC[v][47 - 8*k -: 8], a);
        check("R7 data byte ack", 48'(a), 48'd0);
        mdl[k] = VEC[v][47 - 8*k -: 8];
      end
      bus_stop;
      tick(4);
      check("R5 R6 R4 configuration after write", cfg, model_vec());
    end

    // R3: foreign address ignored
    bus_start;
    wr_byte(8'hA4, a); check("R3 foreign address no ack", 48'(a), 48'd1);
    wr_byte(8'h00, a); check("R3 later byte no ack", 48'(a), 48'd1);
    wr_byte(8'h00, a); check("R3 later byte no ack", 48'(a), 48'd1);
    wr_byte(8'h12, a); check("R3 later byte no ack", 48'(a), 48'd1);
    bus_stop;
    tick(4);
    check("R3 configuration unchanged", cfg, model_vec());

    // R7: overflow bytes acknowledged and dropped
    bus_start;
    wr_byte(8'hD2, a); check("R2 write address ack", 48'(a), 48'd0);
    wr_byte(8'h00, a); check("R4 command byte ack", 48'(a), 48'd0);
    wr_byte(8'h06, a); check("R4 count byte ack", 48'(a), 48'd0);
    for (int k = 0; k < 8; k++) begin
      wr_byte(8'(8'h80 + k), a);
      check("R7 overflow write ack", 48'(a), 48'd0);
      if (k < 6) mdl[k] = 8'(8'h80 + k);
    end
    bus_stop;
    tick(4);
    check("R7 overflow discarded", cfg, model_vec());

    // R8: block read
    bus_start;
    wr_byte(8'hD3, a); check("R2 read address ack", 48'(a), 48'd0);
    rd_byte(1'b0, d);  check("R8 count byte", 48'(d), 48'd6);
    for (int k = 0; k < 6; k++) begin
      rd_byte(1'b0, d);
      check("R8 read data byte", 48'(d), 48'(mdl[k]));
    end
    rd_byte(1'b1, d);  check("R8 read past end", 48'(d), 48'hFF);
    tick(HALF);
    check("R9 released after nack", 48'(sda_oe), 48'd0);
    bus_stop;

    // R9: nack early, then a normal transfer
    bus_start;
    wr_byte(8'hD3, a); check("R2 read address ack", 48'(a), 48'd0);
    rd_byte(1'b1, d);  check("R8 count byte", 48'(d), 48'd6);
    tick(HALF);
    check("R9 released after nack", 48'(sda_oe), 48'd0);
    bus_stop;

    // R10: write then repeated start into a read
    bus_start;
    wr_byte(8'hD2, a); check("R10 write address ack", 48'(a), 48'd0);
    wr_byte(8'h01, a); check("R4 command byte ack", 48'(a), 48'd0);
    wr_byte(8'h01, a); check("R4 count byte ack", 48'(a), 48'd0);
    wr_byte(8'h5A, a); check("R7 data byte ack", 48'(a), 48'd0);
    mdl[0] = 8'h5A;
    bus_start;
    wr_byte(8'hD3, a); check("R10 read address after repeated start", 48'(a), 48'd0);
    rd_byte(1'b0, d);  check("R10 count byte", 48'(d), 48'd6);
    rd_byte(1'b1, d);  check("R10 byte 0 read back", 48'(d), 48'h5A);
    bus_stop;
    tick(4);
    check("R6 configuration after repeated start", cfg, model_vec());

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule